// File: doc/BRIEF.md
# Scan-Line Pixel Serializer

This block turns a frame buffer of one-bit pixels into a serial video stream, one stored line per scan line. A separate timing generator supplies two strobes. One marks the end of horizontal blanking and starts a line. The other marks the end of vertical blanking and returns the engine to the top of the frame. On a line start, the engine fetches the words of the current line from a synchronous-read memory. It shifts their bits out most significant first, holding each pixel for a fixed number of system clocks (four by default). When the last bit has gone out, the engine stops, raises a one-cycle completion pulse and moves its line start address to the next line, ready for the next strobe.

The line index stops at one past the last visible line. At that index the engine plays a line of zeros without touching memory, so every line start during vertical blanking yields a dark line. After reset the engine ignores line starts until it has seen its first end-of-vertical-blanking strobe. This keeps a partial frame from being shown. Frame-buffer writes and sync generation live elsewhere. The frame-buffer memory sits outside the block and is reached through a one-cycle-latency read port. Word k of line L sits at address L*WORDS_PER_LINE + k.

Top module: `scan_out_engine`

## Requirements
- R1: After reset the engine is idle (`busy_o`=0), `pix_o`=0, `line_done_o`=0, `line_idx_o`=0 and no memory read is issued.
- R2: Before the first `vblank_end_i` pulse after reset, `hblank_end_i` pulses have no effect: `busy_o` stays 0, `pix_o` stays 0 and no read is issued.
- R3: A `vblank_end_i` pulse sets `line_idx_o` to 0 on the next cycle and arms the engine for line starts.
- R4: When the engine is armed and idle, an `hblank_end_i` pulse sampled at clock edge E starts a transfer: `busy_o` is 1 from E onward. Pixel n of the line is driven on `pix_o` for the PIX_DIV cycles following edges E+2+n*PIX_DIV through E+1+(n+1)*PIX_DIV.
- R5: A line of index L below VIS_LINES is read from addresses L*WORDS_PER_LINE up to L*WORDS_PER_LINE+WORDS_PER_LINE-1, one read per word, in ascending order. Each word is sent bit WORD_W-1 first and bit 0 last, and words are sent in ascending address order.
- R6: While `busy_o` is 0, `pix_o` is 0.
- R7: `line_done_o` is 1 for exactly one cycle, the cycle right after the last pixel's final cycle. In that same cycle `busy_o` returns to 0.
- R8: At each `line_done_o`, `line_idx_o` increases by one, but never beyond VIS_LINES (480 by default). Once there, it stays there.
- R9: A transfer started at line index VIS_LINES issues no memory reads and drives an all-zero line with the normal timing, including the `line_done_o` pulse.
- R10: An `hblank_end_i` pulse arriving while a transfer is in progress is ignored. The line's pixels, its single completion pulse and its single index step are unchanged.
- R11: A `vblank_end_i` pulse in the middle of a frame restarts the frame: the next line transfer shows line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank_end_i | input | 1 | One-cycle strobe at the end of horizontal blanking; starts a line |
| vblank_end_i | input | 1 | One-cycle strobe at the end of vertical blanking; line index to 0, arms engine |
| rd_en_o | output | 1 | Frame-buffer read request |
| rd_addr_o | output | AW | Frame-buffer word address, AW = clog2((VIS_LINES+1)*WORDS_PER_LINE) |
| rd_data_i | input | WORD_W | Read data, valid the cycle after the request |
| pix_o | output | 1 | Serial pixel output |
| busy_o | output | 1 | A line transfer is in progress |
| line_done_o | output | 1 | One-cycle pulse after the last pixel of a line |
| line_idx_o | output | LW | Index of the next line to send, LW = clog2(VIS_LINES+1) |

## Verification
The bench runs a reduced configuration (three 8-bit words per line, five visible lines) through whole frames and compares every pixel cycle against the frame-buffer contents. This catches word-order, bit-order, hold-time and word-boundary slips, such as a prefetch that lands a word late or repeats the previous one. It drives line starts before the first frame strobe, where a design that forgot the arming flag would read memory and emit pixels. It runs several lines past the last visible one over memory that is deliberately non-zero there, which exposes an index that wraps or keeps climbing, or a blank line that is fetched rather than forced dark. It also fires a stray line start in mid-line and a frame restart in mid-frame, where a careless design would restart the shifter, double-step the index or resume at the wrong line.

// File: rtl/scan_out_pkg.sv
package scan_out_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FILL  = 2'd2,
        ST_SHIFT = 2'd3
    } scan_state_t;

endpackage

// File: rtl/scan_line_ptr.sv
module scan_line_ptr #(
    parameter int VIS_LINES      = 480,
    parameter int WORDS_PER_LINE = 20,
    parameter int LW             = 9,
    parameter int AW             = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vblank_i,
    input  logic          adv_i,
    output logic          armed_o,
    output logic [LW-1:0] line_o,
    output logic [AW-1:0] base_o,
    output logic          blank_o
);

    localparam logic [LW-1:0] LAST_IDX = LW'(VIS_LINES);
    localparam logic [AW-1:0] STEP     = AW'(WORDS_PER_LINE);

    typedef struct packed {
        logic          armed;
        logic [LW-1:0] line;
        logic [AW-1:0] base;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (vblank_i) begin
            ptr_d.armed = 1'b1;
            ptr_d.line  = '0;
            ptr_d.base  = '0;
        end else if (adv_i && (ptr_q.line != LAST_IDX)) begin
            ptr_d.line = ptr_q.line + 1'b1;
            ptr_d.base = ptr_q.base + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign armed_o = ptr_q.armed;
    assign line_o  = ptr_q.line;
    assign base_o  = ptr_q.base;
    assign blank_o = (ptr_q.line == LAST_IDX);

endmodule

// File: rtl/scan_pix_shift.sv
module scan_pix_shift #(
    parameter int WORD_W  = 32,
    parameter int PIX_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] cap_word_i,
    input  logic              run_i,
    output logic              pix_o,
    output logic              word_start_o,
    output logic              word_end_o
);

    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int DW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
    localparam logic [DW-1:0] LAST_DIV = DW'(PIX_DIV - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] nxt;
        logic [BW-1:0]     bitn;
        logic [DW-1:0]     div;
    } shf_t;

    shf_t s_d, s_q;
    logic tick_last;

    assign tick_last = (s_q.div == LAST_DIV);

    always_comb begin
        s_d = s_q;
        if (cap_i) begin
            s_d.nxt = cap_word_i;
        end
        if (load_i) begin
            s_d.sh   = load_word_i;
            s_d.bitn = '0;
            s_d.div  = '0;
        end else if (run_i) begin
            if (tick_last) begin
                s_d.div = '0;
                if (s_q.bitn == LAST_BIT) begin
                    s_d.bitn = '0;
                    s_d.sh   = cap_i ? cap_word_i : s_q.nxt;
                end else begin
                    s_d.bitn = s_q.bitn + 1'b1;
                    s_d.sh   = {s_q.sh[WORD_W-2:0], 1'b0};
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_o        = run_i & s_q.sh[WORD_W-1];
    assign word_start_o = run_i & (s_q.div == '0) & (s_q.bitn == '0);
    assign word_end_o   = run_i & tick_last & (s_q.bitn == LAST_BIT);

endmodule

// File: rtl/scan_out_engine.sv
module scan_out_engine #(
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 20,
    parameter int VIS_LINES      = 480,
    parameter int PIX_DIV        = 4,
    localparam int AW = $clog2((VIS_LINES + 1) * WORDS_PER_LINE),
    localparam int LW = $clog2(VIS_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank_end_i,
    input  logic              vblank_end_i,
    output logic              rd_en_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              pix_o,
    output logic              busy_o,
    output logic              line_done_o,
    output logic [LW-1:0]     line_idx_o
);

    import scan_out_pkg::*;

    localparam int XW = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1;
    localparam logic [XW-1:0] LAST_WORD = XW'(WORDS_PER_LINE - 1);

    typedef struct packed {
        scan_state_t   state;
        logic          blank;
        logic [XW-1:0] word;
        logic [AW-1:0] rptr;
        logic          pend;
        logic          done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              armed;
    logic [AW-1:0]     line_base;
    logic              line_blank;
    logic              adv;
    logic              rd_en;
    logic              load;
    logic [WORD_W-1:0] load_word;
    logic              cap;
    logic [WORD_W-1:0] cap_word;
    logic              run;
    logic              word_start;
    logic              word_end;

    scan_line_ptr #(
        .VIS_LINES      (VIS_LINES),
        .WORDS_PER_LINE (WORDS_PER_LINE),
        .LW             (LW),
        .AW             (AW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .vblank_i (vblank_end_i),
        .adv_i    (adv),
        .armed_o  (armed),
        .line_o   (line_idx_o),
        .base_o   (line_base),
        .blank_o  (line_blank)
    );

    scan_pix_shift #(
        .WORD_W  (WORD_W),
        .PIX_DIV (PIX_DIV)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .load_word_i  (load_word),
        .cap_i        (cap),
        .cap_word_i   (cap_word),
        .run_i        (run),
        .pix_o        (pix_o),
        .word_start_o (word_start),
        .word_end_o   (word_end)
    );

    always_comb begin
        c_d       = c_q;
        c_d.pend  = 1'b0;
        c_d.done  = 1'b0;
        adv       = 1'b0;
        rd_en     = 1'b0;
        load      = 1'b0;
        load_word = '0;
        cap       = 1'b0;
        cap_word  = '0;
        run       = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (hblank_end_i && armed) begin
                    c_d.state = ST_LOAD;
                    c_d.rptr  = line_base;
                    c_d.blank = line_blank;
                    c_d.word  = '0;
                end
            end
            ST_LOAD: begin
                rd_en     = ~c_q.blank;
                if (!c_q.blank) begin
                    c_d.rptr = c_q.rptr + 1'b1;
                end
                c_d.state = ST_FILL;
            end
            ST_FILL: begin
                load      = 1'b1;
                load_word = c_q.blank ? '0 : rd_data_i;
                c_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                run      = 1'b1;
                cap      = c_q.pend;
                cap_word = c_q.blank ? '0 : rd_data_i;
                if (word_start && (c_q.word != LAST_WORD)) begin
                    c_d.pend = 1'b1;
                    if (!c_q.blank) begin
                        rd_en    = 1'b1;
                        c_d.rptr = c_q.rptr + 1'b1;
                    end
                end
                if (word_end) begin
                    if (c_q.word == LAST_WORD) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                        adv       = 1'b1;
                    end else begin
                        c_d.word = c_q.word + 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_en_o     = rd_en;
    assign rd_addr_o   = c_q.rptr;
    assign busy_o      = (c_q.state != ST_IDLE);
    assign line_done_o = c_q.done;

endmodule

// File: rtl/scan_out_chk.sv
module scan_out_chk #(
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 20,
    parameter int VIS_LINES      = 480,
    parameter int AW             = 14,
    parameter int LW             = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hblank_end_i,
    input logic          vblank_end_i,
    input logic          rd_en_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          pix_o,
    input logic          busy_o,
    input logic          line_done_o,
    input logic [LW-1:0] line_idx_o
);

    localparam logic [LW-1:0] LAST_IDX   = LW'(VIS_LINES);
    localparam int            BLANK_BASE = VIS_LINES * WORDS_PER_LINE;

    logic seen_vb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_vb_q <= 1'b0;
        end else if (vblank_end_i) begin
            seen_vb_q <= 1'b1;
        end
    end

    AST_NO_READ_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> seen_vb_q); // R2

    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_vb_q |-> !busy_o); // R2

    AST_VBLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end_i |=> (line_idx_o == '0)); // R3

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pix_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |=> !line_done_o); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> (!busy_o && $past(busy_o))); // R7

    AST_LINE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx_o <= LAST_IDX); // R8

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done_o && !$past(vblank_end_i) && ($past(line_idx_o) != LAST_IDX))
        |-> (line_idx_o == LW'($past(line_idx_o) + 1'b1))); // R8

    AST_NO_BLANK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (int'(rd_addr_o) < BLANK_BASE)); // R9

endmodule

bind scan_out_engine scan_out_chk #(
    .WORD_W         (WORD_W),
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .VIS_LINES      (VIS_LINES),
    .AW             (AW),
    .LW             (LW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hblank_end_i (hblank_end_i),
    .vblank_end_i (vblank_end_i),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .pix_o        (pix_o),
    .busy_o       (busy_o),
    .line_done_o  (line_done_o),
    .line_idx_o   (line_idx_o)
);

// File: tb/scan_out_engine_tb.sv
module scan_out_engine_tb;

    localparam int WW   = 8;
    localparam int WPL  = 3;
    localparam int VIS  = 5;
    localparam int DIV  = 4;
    localparam int AW   = $clog2((VIS + 1) * WPL);
    localparam int LW   = $clog2(VIS + 1);
    localparam int NPIX = WW * WPL;
    localparam int MEMN = (VIS + 1) * WPL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb = 1'b0;
    logic          vb = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [WW-1:0] rd_data = '0;
    logic          pix;
    logic          busy;
    logic          done;
    logic [LW-1:0] line_idx;

    logic [WW-1:0] mem [0:MEMN-1];
    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scan_out_engine #(
        .WORD_W         (WW),
        .WORDS_PER_LINE (WPL),
        .VIS_LINES      (VIS),
        .PIX_DIV        (DIV)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hblank_end_i (hb),
        .vblank_end_i (vb),
        .rd_en_o      (rd_en),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .pix_o        (pix),
        .busy_o       (busy),
        .line_done_o  (done),
        .line_idx_o   (line_idx)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_cnt <= rd_cnt + 1;
            if (int'(rd_addr) < MEMN) rd_data <= mem[rd_addr];
            else rd_data <= '0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_pix(input int l, input int n);
        logic [WW-1:0] w;
        if (l >= VIS) return 1'b0;
        w = mem[l * WPL + n / WW];
        return w[WW - 1 - (n % WW)];
    endfunction

    // Runs one line transfer at expected index l; extra fires a stray line start mid-line (R10)
    task automatic run_line(input int l, input bit extra);
        int errs = 0;
        int bad_n = -1;
        int bad_a = 0;
        int rd0;
        int nxt;
        logic e;
        rd0 = rd_cnt;
        nxt = (l >= VIS) ? VIS : l + 1;
        @(negedge clk) hb = 1'b1;
        @(negedge clk) hb = 1'b0;
        chk(busy == 1'b1, "R4", "busy after line start", int'(busy), 1);
        @(negedge clk);
        chk(pix == 1'b0 && busy == 1'b1, "R4", "pix during fetch", int'(pix), 0);
        for (int n = 0; n < NPIX; n++) begin
            for (int d = 0; d < DIV; d++) begin
                @(negedge clk);
                e = exp_pix(l, n);
                if (pix !== e || busy !== 1'b1 || done !== 1'b0) begin
                    errs++;
                    if (bad_n < 0) begin bad_n = n; bad_a = int'(pix); end
                end
                hb = (extra && n == 5 && d == 0);
            end
        end
        hb = 1'b0;
        if (l >= VIS)
            chk(errs == 0, "R9", $sformatf("blank line pixel %0d", bad_n), bad_a, 0);
        else
            chk(errs == 0, extra ? "R10" : "R5", $sformatf("line %0d pixel %0d", l, bad_n),
                bad_a, (bad_n < 0) ? bad_a : int'(exp_pix(l, bad_n)));
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R7", "done pulse at line end", int'({done, busy}), 2);
        chk(int'(line_idx) == nxt, "R8", "line index after done", int'(line_idx), nxt);
        @(negedge clk);
        chk(done == 1'b0 && pix == 1'b0, "R7", "done is one cycle", int'(done), 0);
        if (l >= VIS)
            chk(rd_cnt == rd0, "R9", "reads on blank line", rd_cnt - rd0, 0);
        else
            chk(rd_cnt == rd0 + WPL, "R5", "reads per line", rd_cnt - rd0, WPL);
    endtask

    task automatic pulse_vb();
        @(negedge clk) vb = 1'b1;
        @(negedge clk) vb = 1'b0;
        chk(line_idx == '0, "R3", "line index after frame strobe", int'(line_idx), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int bad;
        for (int a = 0; a < MEMN; a++) mem[a] = WW'(a * 37 + 11);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && pix == 1'b0 && done == 1'b0, "R1", "outputs in reset",
            int'({busy, pix, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_idx == '0 && rd_en == 1'b0, "R1", "index and reads after reset",
            int'(line_idx), 0);

        // R2: line starts before the first frame strobe do nothing
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) hb = 1'b1;
            @(negedge clk) hb = 1'b0;
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                if (busy || pix) bad++;
            end
        end
        chk(bad == 0, "R2", "activity before arming", bad, 0);
        chk(rd_cnt == 0, "R2", "reads before arming", rd_cnt, 0);

        pulse_vb();
        for (int l = 0; l < VIS; l++) run_line(l, l == 1);

        // R6: idle output stays dark
        bad = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (pix || busy) bad++;
        end
        chk(bad == 0, "R6", "pix while idle", bad, 0);

        // R8/R9: saturation and blank replay
        for (int k = 0; k < 3; k++) run_line(VIS, 1'b0);

        pulse_vb();
        run_line(0, 1'b0);
        run_line(1, 1'b0);
        // R11: restart mid-frame
        pulse_vb();
        run_line(0, 1'b0);
        run_line(1, 1'b0);
        run_line(2, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule